// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block is the status front end of a parallel NOR flash. A host reaches it through a plain bus with an address, 16-bit write data, a write pulse and a read strobe. An internal operation engine reports to it through start, busy, done and fail signals. While an operation runs, and in some cases after it ends, a host read returns a status word in place of array data. Bit 7 of that word is the polling bit. Bit 6 is a toggle bit. Bits 5, 3 and 2 pass through the engine's own status flags.

A one-bit status mode selects how the block reports. Mode 0 (the power-up value) drives the polling bit from the complemented last loaded data, and returns the device to array reads on its own after a successful operation. Mode 1 drives a plain ready flag on the polling bit. In mode 1 the block holds status until the host sends an exit command. A failed operation holds status in either mode until that exit command arrives.

Commands use three unlock cycles: (0x5555, 0x00AA), then (0x2AAA, 0x0055), then (0x5555, command). Command 0x00E0 is followed by a fourth write whose data is the new mode. Command 0x00F0 is the exit.

Top module: `flash_status_unit`

## Requirements
- R1: A power-on reset (`rst_n` low at a clock edge) sets the mode to 0 and selects array reads. The mode-setting sequence accepts only the data values 0x0000 and 0x0001.
- R2: A pulse on `extRst` leaves the mode unchanged. It returns the block to array reads and clears any partly received command sequence.
- R3: The mode is written by four writes: (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x00E0), then (any address, value). The new mode takes effect on the clock edge of the fourth write.
- R4: In mode 0, a `engDone` pulse without `engFail` returns reads to array data from the next cycle on.
- R5: In mode 1, a successful operation leaves the block in status. Bit 7 then reads 1. The exit sequence (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x00F0) returns the block to array reads.
- R6: In either mode, `engDone` together with `engFail` keeps the block in status until an exit sequence is received.
- R7: In mode 0, status bit 7 reads the inverse of `loadedBit7` after a program start, and 0 after an erase start.
- R8: In mode 1, status bit 7 reads 0 from the operation start until `engDone`.
- R9: While `engBusy` is high, each falling edge of `busRd` inverts status bit 6. While `engBusy` is low, bit 6 holds its value.
- R10: `engStart` clears status bit 6, so the first status read after a start returns 0 on bit 6.
- R11: In status, bits 5, 3 and 2 equal `auxFlags[2]`, `auxFlags[1]` and `auxFlags[0]`, and bits 15:8, 4, 1 and 0 are 0. Outside status, `busRdData` equals `arrayData`.
- R12: A write that does not match the expected step aborts the sequence with no change to the mode. An exit sequence that completes while `engBusy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| extRst | input | 1 | External reset; does not touch the mode |
| busAddr | input | 16 | Host write address |
| busWrData | input | 16 | Host write data |
| busWr | input | 1 | Host write pulse, one cycle per bus write |
| busRd | input | 1 | Host read strobe; its falling edge ends a read |
| busRdData | output | 16 | Read data: array data or status word |
| arrayData | input | 16 | Data from the memory array |
| engStart | input | 1 | Operation start pulse |
| engIsErase | input | 1 | Marks the starting operation as an erase |
| engBusy | input | 1 | Operation in progress |
| engDone | input | 1 | Operation end pulse |
| engFail | input | 1 | Qualifies `engDone` as a failure |
| loadedBit7 | input | 1 | Bit 7 of the last loaded program word |
| auxFlags | input | 3 | Engine status flags shown on bits 5, 3, 2 |
| inStatusMode | output | 1 | High while reads return the status word |

## Verification
The assertions assume that `engStart` and `engDone` never arrive in the same cycle. They also assume that `engBusy` stays high from a start until its done pulse, and that no exit sequence finishes in the same cycle as a done pulse. The stimulus raises busy one cycle after each start pulse, drops it together with done, and always leaves idle cycles between a done and any following command. Bus writes are single-cycle pulses with idle cycles between them.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_KEY1,
    SEQ_KEY2,
    SEQ_MODEVAL
  } seqState_t;

  typedef struct packed {
    logic startOp;
    logic opErase;
    logic togAdv;
    logic modeWr;
    logic modeVal;
  } ctlStrobe_t;
endpackage

// File: rtl/flash_stat_ctrl.sv
module flash_stat_ctrl
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA,
  parameter logic [DATA_W-1:0] KEY_DATA_A = 16'h00AA,
  parameter logic [DATA_W-1:0] KEY_DATA_B = 16'h0055,
  parameter logic [DATA_W-1:0] OP_SETMODE = 16'h00E0,
  parameter logic [DATA_W-1:0] OP_LEAVE   = 16'h00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              extRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              engStart,
  input  logic              engIsErase,
  input  logic              engBusy,
  input  logic              engDone,
  input  logic              engFail,
  input  logic              modeBit,
  output ctlStrobe_t        strobes,
  output logic              statusMode,
  output logic              opFinished
);
  localparam logic [DATA_W-1:0] MODE_ONE = DATA_W'(1);

  seqState_t seqState, seqNext;
  logic      rdPrev;
  logic      failLatched;
  logic      leaveHit;

  always_comb begin
    seqNext        = SEQ_IDLE;
    leaveHit       = 1'b0;
    strobes        = '0;
    strobes.startOp = engStart;
    strobes.opErase = engIsErase;
    strobes.togAdv  = rdPrev && !busRd && engBusy;
    if (busWr) begin
      unique case (seqState)
        SEQ_IDLE:
          if (busAddr == KEY_ADDR_A && busWrData == KEY_DATA_A) seqNext = SEQ_KEY1;
        SEQ_KEY1:
          if (busAddr == KEY_ADDR_B && busWrData == KEY_DATA_B) seqNext = SEQ_KEY2;
        SEQ_KEY2:
          if (busAddr == KEY_ADDR_A && busWrData == OP_SETMODE) seqNext = SEQ_MODEVAL;
          else if (busAddr == KEY_ADDR_A && busWrData == OP_LEAVE) leaveHit = 1'b1;
        SEQ_MODEVAL:
          if (busWrData == '0 || busWrData == MODE_ONE) begin
            strobes.modeWr  = 1'b1;
            strobes.modeVal = busWrData[0];
          end
        default: seqNext = SEQ_IDLE;
      endcase
    end else begin
      seqNext = seqState;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || extRst) begin
      seqState    <= SEQ_IDLE;
      rdPrev      <= 1'b0;
      statusMode  <= 1'b0;
      failLatched <= 1'b0;
      opFinished  <= 1'b0;
    end else begin
      seqState <= seqNext;
      rdPrev   <= busRd;
      if (engStart) begin
        statusMode  <= 1'b1;
        failLatched <= 1'b0;
        opFinished  <= 1'b0;
      end else begin
        if (engDone) begin
          opFinished <= 1'b1;
          if (engFail) failLatched <= 1'b1;
          else if (!modeBit) statusMode <= 1'b0;
        end
        if (leaveHit && !engBusy) begin
          statusMode  <= 1'b0;
          failLatched <= 1'b0;
        end
      end
    end
  end

  AST_AUTO_RETURN: assert property (@(posedge clk) disable iff (!rst_n || extRst)
    (engDone && !engFail && !modeBit && !engStart) |=> !statusMode); // R4

  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || extRst)
    (statusMode && failLatched && !leaveHit) |=> statusMode); // R6

  AST_BUSY_LEAVE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n || extRst)
    (statusMode && engBusy && !engDone) |=> statusMode); // R12

  AST_START_ENTERS: assert property (@(posedge clk) disable iff (!rst_n || extRst)
    engStart |=> statusMode); // R10
endmodule

// File: rtl/flash_stat_dp.sv
module flash_stat_dp
  import flash_stat_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int POLL_B  = 7,
  parameter int TOG_B   = 6,
  parameter int AUX_N   = 3,
  parameter int AUX_POS [AUX_N] = '{2, 3, 5}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              extRst,
  input  ctlStrobe_t        strobes,
  input  logic              statusMode,
  input  logic              opFinished,
  input  logic              engBusy,
  input  logic              loadedBit7,
  input  logic [AUX_N-1:0]  auxFlags,
  input  logic [DATA_W-1:0] arrayData,
  output logic              modeBit,
  output logic [DATA_W-1:0] busRdData
);
  logic              togBit;
  logic              eraseKind;
  logic [DATA_W-1:0] statWord;

  always_ff @(posedge clk) begin
    if (!rst_n) modeBit <= 1'b0;
    else if (strobes.modeWr) modeBit <= strobes.modeVal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || extRst) begin
      togBit    <= 1'b0;
      eraseKind <= 1'b0;
    end else if (strobes.startOp) begin
      togBit    <= 1'b0;
      eraseKind <= strobes.opErase;
    end else if (strobes.togAdv) begin
      togBit <= ~togBit;
    end
  end

  always_comb begin
    statWord = '0;
    statWord[POLL_B] = modeBit ? opFinished : (eraseKind ? 1'b0 : ~loadedBit7);
    statWord[TOG_B]  = togBit;
  end

  for (genvar g = 0; g < AUX_N; g++) begin : g_aux
    assign statWord_aux[g] = auxFlags[g];
  end
  logic [AUX_N-1:0] statWord_aux;

  always_comb begin
    busRdData = statusMode ? statWord : arrayData;
    if (statusMode) begin
      for (int k = 0; k < AUX_N; k++) busRdData[AUX_POS[k]] = statWord_aux[k];
    end
  end

  AST_MODE_KEEPS_ON_EXTRST: assert property (@(posedge clk) disable iff (!rst_n)
    (extRst && !strobes.modeWr) |=> $stable(modeBit)); // R2

  AST_TOG_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n || extRst)
    (!engBusy && !strobes.startOp) |=> $stable(togBit)); // R9

  AST_TOG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n || extRst)
    strobes.startOp |=> !togBit); // R10
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int AUX_N  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              extRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              engStart,
  input  logic              engIsErase,
  input  logic              engBusy,
  input  logic              engDone,
  input  logic              engFail,
  input  logic              loadedBit7,
  input  logic [AUX_N-1:0]  auxFlags,
  output logic              inStatusMode
);
  ctlStrobe_t strobes;
  logic       modeBit;
  logic       opFinished;

  flash_stat_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .extRst     (extRst),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busWr      (busWr),
    .busRd      (busRd),
    .engStart   (engStart),
    .engIsErase (engIsErase),
    .engBusy    (engBusy),
    .engDone    (engDone),
    .engFail    (engFail),
    .modeBit    (modeBit),
    .strobes    (strobes),
    .statusMode (inStatusMode),
    .opFinished (opFinished)
  );

  flash_stat_dp #(.DATA_W(DATA_W), .AUX_N(AUX_N)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .extRst     (extRst),
    .strobes    (strobes),
    .statusMode (inStatusMode),
    .opFinished (opFinished),
    .engBusy    (engBusy),
    .loadedBit7 (loadedBit7),
    .auxFlags   (auxFlags),
    .arrayData  (arrayData),
    .modeBit    (modeBit),
    .busRdData  (busRdData)
  );

  AST_MODE1_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n || extRst)
    (inStatusMode && modeBit && opFinished) |-> busRdData[7]); // R5

  AST_MODE1_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n || extRst)
    (inStatusMode && modeBit && !opFinished) |-> !busRdData[7]); // R8
endmodule

// File: tb/test_flash_status_unit.sv
module test_flash_status_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        extRst = 1'b0;
  logic [15:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busRdData;
  logic [15:0] arrayData = 16'h1234;
  logic        engStart = 1'b0;
  logic        engIsErase = 1'b0;
  logic        engBusy = 1'b0;
  logic        engDone = 1'b0;
  logic        engFail = 1'b0;
  logic        loadedBit7 = 1'b0;
  logic [2:0]  auxFlags = '0;
  logic        inStatusMode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";

  // reference model state
  bit mMode = 0, mStat = 0, mTog = 0, mErase = 0, mDone = 0, mFail = 0, mRdPrev = 0;
  int mSeq = 0;

  flash_status_unit i_flash_status_unit (
    .clk(clk), .rst_n(rst_n), .extRst(extRst), .busAddr(busAddr),
    .busWrData(busWrData), .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
    .arrayData(arrayData), .engStart(engStart), .engIsErase(engIsErase),
    .engBusy(engBusy), .engDone(engDone), .engFail(engFail),
    .loadedBit7(loadedBit7), .auxFlags(auxFlags), .inStatusMode(inStatusMode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      mMode = 0; mStat = 0; mTog = 0; mErase = 0; mDone = 0; mFail = 0; mRdPrev = 0; mSeq = 0;
    end else if (extRst) begin
      mStat = 0; mTog = 0; mErase = 0; mDone = 0; mFail = 0; mRdPrev = 0; mSeq = 0;
    end else begin
      bit fall;
      bit leave;
      fall = mRdPrev && !busRd;
      mRdPrev = busRd;
      leave = 0;
      if (busWr) begin
        case (mSeq)
          0: mSeq = (busAddr == 16'h5555 && busWrData == 16'h00AA) ? 1 : 0;
          1: mSeq = (busAddr == 16'h2AAA && busWrData == 16'h0055) ? 2 : 0;
          2: begin
            if (busAddr == 16'h5555 && busWrData == 16'h00E0) mSeq = 3;
            else begin
              if (busAddr == 16'h5555 && busWrData == 16'h00F0) leave = 1;
              mSeq = 0;
            end
          end
          default: begin
            if (busWrData == 16'h0000) mMode = 0;
            else if (busWrData == 16'h0001) mMode = 1;
            mSeq = 0;
          end
        endcase
      end
      if (engStart) begin
        mStat = 1; mTog = 0; mErase = engIsErase; mDone = 0; mFail = 0;
      end else begin
        if (fall && engBusy) mTog = !mTog;
        if (engDone) begin
          mDone = 1;
          if (engFail) mFail = 1;
          else if (!mMode) mStat = 0;
        end
        if (leave && !engBusy) begin mStat = 0; mFail = 0; end
      end
    end
  end

  function automatic logic [15:0] expRd();
    logic [15:0] w;
    if (!mStat) return arrayData;
    w = '0;
    w[7] = mMode ? mDone : (mErase ? 1'b0 : !loadedBit7);
    w[6] = mTog;
    w[5] = auxFlags[2];
    w[3] = auxFlags[1];
    w[2] = auxFlags[0];
    return w;
  endfunction

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (busRdData !== expRd() || inStatusMode !== mStat) begin
      errors++;
      $display("FAIL %s: rd=%h stat=%b expected rd=%h stat=%b", curReq,
               busRdData, inStatusMode, expRd(), mStat);
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    tick(); busWr = 1; busAddr = a; busWrData = d;
    tick(); busWr = 0;
    tick();
  endtask

  task automatic rd();
    tick(); busRd = 1;
    tick(); busRd = 0;
    tick();
  endtask

  task automatic setMode(logic [15:0] v);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00E0); wr(16'h0123, v);
  endtask

  task automatic leaveCmd();
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00F0);
  endtask

  task automatic startOp(bit erase);
    tick(); engStart = 1; engIsErase = erase;
    tick(); engStart = 0; engBusy = 1;
  endtask

  task automatic finishOp(bit fail);
    tick(); engDone = 1; engFail = fail; engBusy = 0;
    tick(); engDone = 0; engFail = 0;
    tick(2);
  endtask

  initial begin
    curReq = "R1"; tick(3); rst_n = 1; tick(2);
    arrayData = 16'hBEEF; tick(2);

    curReq = "R7_R10_R9"; loadedBit7 = 1; auxFlags = 3'b101;
    startOp(0); rd(); rd(); rd(); loadedBit7 = 0; rd();
    curReq = "R11"; auxFlags = 3'b010; rd(); auxFlags = 3'b111; tick(2);
    curReq = "R4"; finishOp(0); arrayData = 16'h5A5A; tick(2);

    curReq = "R7_erase"; startOp(1); rd(); rd();
    curReq = "R9_idle"; finishOp(0); rd(); rd();

    curReq = "R12_abort"; wr(16'h5555, 16'h00AA); wr(16'h1111, 16'h0055);
    wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00E0);
    setMode(16'h0002); startOp(0); rd(); finishOp(0); tick(2);

    curReq = "R3"; setMode(16'h0001);
    curReq = "R8"; loadedBit7 = 0; startOp(0); rd(); rd();
    curReq = "R12_busy_leave"; leaveCmd(); rd();
    curReq = "R5"; finishOp(0); rd(); rd(); leaveCmd(); tick(2);

    curReq = "R6_mode1"; startOp(1); rd(); finishOp(1); rd(); tick(3); leaveCmd(); tick(2);
    curReq = "R2"; startOp(0); rd();
    tick(); extRst = 1; tick(); extRst = 0; engBusy = 0; tick(2);
    curReq = "R2_mode_kept"; startOp(0); finishOp(0); rd(); leaveCmd();

    curReq = "R3_back"; setMode(16'h0000);
    curReq = "R6_mode0"; loadedBit7 = 1; startOp(0); rd(); finishOp(1); rd(); tick(3);
    leaveCmd(); tick(2);
    curReq = "R2_seq"; wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055);
    tick(); extRst = 1; tick(); extRst = 0;
    wr(16'h5555, 16'h00E0); wr(16'h0000, 16'h0001);
    startOp(0); finishOp(0); tick(2);

    curReq = "R1_por"; setMode(16'h0001); tick(); rst_n = 0; tick(2); rst_n = 1;
    startOp(0); finishOp(0); tick(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule